// File: doc/BRIEF.md
# Processor Reset Supervisor with Watchdog

This block drives the reset line of a processor from three sources: an undervoltage flag from an external comparator, a manual reset pin with a glitch filter, and a watchdog that the running software must service by toggling a kick pin. It runs from one clock and has no reset input of its own. It powers up with reset asserted and releases the reset only after a full stretch period.

Each cause asserts reset. Reset stays asserted for a fixed number of cycles after the last cause has gone away. Both polarities of the reset are brought out. The watchdog restarts on every level change of the kick pin and is held at zero while reset is active. It is switched off entirely while a separate flag reports that the kick pin is floating.

The timeout, the stretch length and the glitch window are parameters given in clock cycles. Their defaults correspond to 1.6 s, 200 ms and 100 ns at 100 MHz. The manual reset and kick pins each pass through a two-flop synchronizer. The undervoltage flag and the floating flag are taken as synchronous to the clock.

Top module: `rstwd_ctrl`

## Requirements
- R1: An undervoltage flag sampled high at a clock edge makes the reset output active after that same edge.
- R2: If a cause (undervoltage, filtered manual reset or watchdog expiry) is last present at edge k, the reset releases at edge k+STRETCH_CYC and stays active at every edge before that.
- R3: If the watchdog starts counting from zero after edge c and sees no kick, the reset becomes active at edge c+WD_TIMEOUT_CYC and not before.
- R4: A rising level change and a falling level change of the kick pin both restart the watchdog. A kick that lasts one clock cycle is seen as two changes. A change made after edge p clears the count at edge p+3, so the next expiry falls at edge p+3+WD_TIMEOUT_CYC.
- R5: While reset is active the watchdog is held at zero. After a release at edge E with no kicks, the next expiry lands exactly at edge E+WD_TIMEOUT_CYC, however long the reset lasted.
- R6: While the floating flag is high the watchdog never asserts reset.
- R7: The manual reset pin (active low) asserts reset only after its synchronized level has been low for GLITCH_CYC consecutive samples. A pin that goes low after edge m and is held low for GLITCH_CYC edges gives an active reset at edge m+GLITCH_CYC+3. A shorter low pulse has no effect on the reset outputs.
- R8: The active-low and active-high reset outputs are always exact complements.
- R9: Without any cause present, the block holds reset active from time zero until it releases at edge STRETCH_CYC.
- R10: A watchdog expiry gives one reset pulse exactly STRETCH_CYC cycles long. Afterwards the watchdog counts again from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| uv_i | input | 1 | Undervoltage flag, high while the supply is below threshold |
| mr_n_i | input | 1 | Raw manual reset pin, active low, asynchronous |
| kick_i | input | 1 | Watchdog kick pin, asynchronous, serviced by toggling |
| kick_float_i | input | 1 | High while the kick pin is floating; disables the watchdog |
| rst_n_o | output | 1 | Reset to the processor, active low |
| rst_o | output | 1 | Reset to the processor, active high |

## Verification
A wrong count in the stretch counter moves the release edge of the reset. This shows at the ports on the first release after the fault, early or late by the size of the error. A watchdog counter that is not cleared by reset, by a kick or by the floating flag brings the next timeout forward or back. That error becomes visible within one timeout period after release, which is why the timeout edge is checked to the exact cycle after a long reset and after a single-cycle kick. A glitch filter that counts one sample too few or too many shows at once: a pulse of window length minus one then asserts reset, or a pulse of exactly window length does not.

// File: rtl/rstwd_pkg.sv
package rstwd_pkg;
  // Bits needed to hold the values 0 .. n-1 (at least one bit).
  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rstwd_sync2.sv
module rstwd_sync2 #(
  parameter int          W    = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta = INIT;
  logic [W-1:0] held = INIT;

  always_ff @(posedge clk) begin
    meta <= d;
    held <= meta;
  end

  assign q = held;
endmodule

// File: rtl/rstwd_glitch.sv
module rstwd_glitch #(
  parameter int WIN = 10
) (
  input  logic clk,
  input  logic lvl_n,   // synchronized pin, active low
  output logic low_ok   // pin has been low for WIN samples
);
  import rstwd_pkg::*;

  generate
    if (WIN <= 1) begin : g_bypass
      logic low_q = 1'b0;
      always_ff @(posedge clk) low_q <= ~lvl_n;
      assign low_ok = low_q;
    end else begin : g_count
      localparam int CW = cnt_bits(WIN);
      localparam logic [CW-1:0] FULL = CW'(WIN - 1);
      logic [CW-1:0] run   = '0;
      logic          low_q = 1'b0;

      always_ff @(posedge clk) begin
        if (lvl_n) begin
          run   <= '0;
          low_q <= 1'b0;
        end else if (run == FULL) begin
          low_q <= 1'b1;
        end else begin
          run <= run + 1'b1;
        end
      end
      assign low_ok = low_q;
    end
  endgenerate
endmodule

// File: rtl/rstwd_wdog.sv
module rstwd_wdog #(
  parameter int TIMEOUT = 1000,
  parameter int CW      = rstwd_pkg::cnt_bits(TIMEOUT)
) (
  input  logic          clk,
  input  logic          hold,    // reset active or watchdog disabled
  input  logic          kick,    // single-cycle level-change strobe
  output logic          expire,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q = '0;

  assign expire = !hold && !kick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (hold || kick || expire) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;
endmodule

// File: rtl/rstwd_ctrl.sv
module rstwd_ctrl #(
  parameter int WD_TIMEOUT_CYC = 160_000_000,
  parameter int STRETCH_CYC    = 20_000_000,
  parameter int GLITCH_CYC     = 10
) (
  input  logic clk,
  input  logic uv_i,
  input  logic mr_n_i,
  input  logic kick_i,
  input  logic kick_float_i,
  output logic rst_n_o,
  output logic rst_o
);
  import rstwd_pkg::*;

  localparam int WD_W = cnt_bits(WD_TIMEOUT_CYC);
  localparam int ST_W = cnt_bits(STRETCH_CYC);
  localparam logic [ST_W-1:0] ST_LOAD = ST_W'(STRETCH_CYC - 1);

  // Synchronize the two asynchronous pins: bit 1 = manual reset, bit 0 = kick.
  logic [1:0] pins_s;
  rstwd_sync2 #(.W(2), .INIT(2'b10)) u_sync (
    .clk (clk),
    .d   ({mr_n_i, kick_i}),
    .q   (pins_s)
  );

  logic mr_s, kick_s;
  assign mr_s   = pins_s[1];
  assign kick_s = pins_s[0];

  logic kick_d = 1'b0;
  always_ff @(posedge clk) kick_d <= kick_s;

  logic kick_edge;
  assign kick_edge = kick_s ^ kick_d;

  logic mr_low;
  rstwd_glitch #(.WIN(GLITCH_CYC)) u_glitch (
    .clk    (clk),
    .lvl_n  (mr_s),
    .low_ok (mr_low)
  );

  logic            rst_q = 1'b1;
  logic            wd_expire;
  logic [WD_W-1:0] wd_cnt;

  rstwd_wdog #(.TIMEOUT(WD_TIMEOUT_CYC), .CW(WD_W)) u_wdog (
    .clk    (clk),
    .hold   (rst_q | kick_float_i),
    .kick   (kick_edge),
    .expire (wd_expire),
    .count  (wd_cnt)
  );

  // Stretch: reload on any cause, count down, release once empty.
  logic            cause;
  logic [ST_W-1:0] stretch_q = ST_LOAD;

  assign cause = uv_i | mr_low | wd_expire;

  always_ff @(posedge clk) begin
    if (cause) begin
      stretch_q <= ST_LOAD;
      rst_q     <= 1'b1;
    end else if (stretch_q != '0) begin
      stretch_q <= stretch_q - 1'b1;
      rst_q     <= 1'b1;
    end else begin
      rst_q <= 1'b0;
    end
  end

  assign rst_o   = rst_q;
  assign rst_n_o = ~rst_q;
endmodule

// File: rtl/rstwd_ctrl_chk.sv
module rstwd_ctrl_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          uv_i,
  input logic          kick_float_i,
  input logic          rst_o,
  input logic          rst_n_o,
  input logic          mr_s,
  input logic          mr_low,
  input logic          kick_edge,
  input logic          wd_expire,
  input logic [CW-1:0] wd_cnt
);
  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  assert_uv_forces_R1: assert property (@(posedge clk) disable iff (!started)
    uv_i |=> rst_o);

  assert_release_clean_R2: assert property (@(posedge clk) disable iff (!started)
    $fell(rst_o) |-> (!$past(uv_i) && !$past(mr_low) && !$past(wd_expire)));

  assert_expire_resets_R3: assert property (@(posedge clk) disable iff (!started)
    wd_expire |=> rst_o);

  assert_kick_clears_R4: assert property (@(posedge clk) disable iff (!started)
    kick_edge |=> (wd_cnt == '0));

  assert_frozen_in_reset_R5: assert property (@(posedge clk) disable iff (!started)
    rst_o |=> (wd_cnt == '0));

  assert_float_disables_R6: assert property (@(posedge clk) disable iff (!started)
    kick_float_i |=> !wd_expire);

  assert_filter_needs_low_R7: assert property (@(posedge clk) disable iff (!started)
    $rose(mr_low) |-> !$past(mr_s));

  assert_complement_R8: assert property (@(posedge clk) disable iff (!started)
    rst_o != rst_n_o);
endmodule

bind rstwd_ctrl rstwd_ctrl_chk #(.CW(WD_W)) u_chk (
  .clk          (clk),
  .uv_i         (uv_i),
  .kick_float_i (kick_float_i),
  .rst_o        (rst_o),
  .rst_n_o      (rst_n_o),
  .mr_s         (mr_s),
  .mr_low       (mr_low),
  .kick_edge    (kick_edge),
  .wd_expire    (wd_expire),
  .wd_cnt       (wd_cnt)
);

// File: tb/rstwd_ctrl_test.sv
module rstwd_ctrl_test;
  localparam int T = 200;
  localparam int S = 50;
  localparam int G = 6;

  logic clk = 1'b0;
  logic uv = 1'b0, mr_n = 1'b1, kick = 1'b0, flt = 1'b1;
  logic rst_n, rst;
  int   cyc = 0;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rstwd_ctrl #(.WD_TIMEOUT_CYC(T), .STRETCH_CYC(S), .GLITCH_CYC(G)) uut (
    .clk          (clk),
    .uv_i         (uv),
    .mr_n_i       (mr_n),
    .kick_i       (kick),
    .kick_float_i (flt),
    .rst_n_o      (rst_n),
    .rst_o        (rst)
  );

  task automatic at(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic chk(input logic exp, input string tag);
    n_chk++;
    if (rst !== exp || rst_n !== !exp) begin
      n_fail++;
      $display("FAIL %s @cyc %0d: rst_o=%0b rst_n_o=%0b, expected rst_o=%0b rst_n_o=%0b",
               tag, cyc, rst, rst_n, exp, !exp);
    end
  endtask

  // Watch a window, counting any active reset; one check at the end.
  task automatic quiet(input int ncyc, input string tag);
    int hits = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (rst !== 1'b0 || rst_n !== 1'b1) hits++;
    end
    n_chk++;
    if (hits != 0) begin
      n_fail++;
      $display("FAIL %s: %0d cycles with reset active, expected 0", tag, hits);
    end
  endtask

  task automatic t_power_on();
    @(negedge clk);
    chk(1'b1, "R9 active after first edge");
    at(S - 1); chk(1'b1, "R9 still active before stretch end");
    at(S);     chk(1'b0, "R9 released at edge STRETCH");
  endtask

  task automatic t_float();
    quiet(3 * T, "R6 floating kick pin never resets");
  endtask

  task automatic t_timeout(output int rel);
    int c0 = cyc;
    flt = 1'b0;
    at(c0 + T - 1);         chk(1'b0, "R3 no reset before timeout");
    at(c0 + T);             chk(1'b1, "R3 reset at timeout");
    at(c0 + T + S - 1);     chk(1'b1, "R10 pulse held");
    at(c0 + T + S);         chk(1'b0, "R10 pulse is STRETCH long");
    at(c0 + 2 * T + S - 1); chk(1'b0, "R10 counts again from zero");
    at(c0 + 2 * T + S);     chk(1'b1, "R10 second timeout");
    rel = c0 + 2 * T + 2 * S;
    at(rel);                chk(1'b0, "R10 second release");
  endtask

  task automatic t_kick_toggle(output int rel);
    int x = cyc;
    int hits = 0;
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < T / 2; j++) begin
        @(negedge clk);
        if (rst !== 1'b0) hits++;
      end
      kick = ~kick;
      x = cyc;
    end
    n_chk++;
    if (hits != 0) begin
      n_fail++;
      $display("FAIL R4 toggling kick: %0d reset cycles, expected 0", hits);
    end
    at(x + 3 + T - 1); chk(1'b0, "R4 timeout restarted by last change");
    at(x + 3 + T);     chk(1'b1, "R4 timeout after last change");
    rel = x + 3 + T + S;
    at(rel);
  endtask

  task automatic t_kick_pulse(output int rel);
    int e = cyc;
    int p = e + T - 20;
    at(p);     kick = 1'b1;
    at(p + 1); kick = 1'b0;
    at(e + T + 5);     chk(1'b0, "R4 single-cycle kick seen");
    at(p + 4 + T - 1); chk(1'b0, "R4 falling change also clears");
    at(p + 4 + T);     chk(1'b1, "R4 timeout after pulse");
    rel = p + 4 + T + S;
    at(rel);           chk(1'b0, "R2 release after pulse");
  endtask

  task automatic t_uv(output int rel);
    int u0 = cyc;
    int u1 = u0 + T + 50;
    uv = 1'b1;
    at(u0 + 1);         chk(1'b1, "R1 undervoltage asserts next edge");
    at(u1);             uv = 1'b0;
    at(u1 + S - 1);     chk(1'b1, "R2 held after undervoltage");
    at(u1 + S);         chk(1'b0, "R2 release after undervoltage");
    at(u1 + S + T - 1); chk(1'b0, "R5 watchdog frozen during reset");
    at(u1 + S + T);     chk(1'b1, "R5 full period after release");
    rel = u1 + 2 * S + T;
    at(rel);
  endtask

  task automatic t_mr();
    int m0 = cyc;
    int m1;
    flt  = 1'b1;
    mr_n = 1'b0;
    at(m0 + G - 1); mr_n = 1'b1;
    quiet(G + 12, "R7 short low pulse ignored");
    m1 = cyc;
    mr_n = 1'b0;
    at(m1 + G);         mr_n = 1'b1;
    at(m1 + G + 2);     chk(1'b0, "R7 not yet accepted");
    at(m1 + G + 3);     chk(1'b1, "R7 full-window press asserts");
    at(m1 + G + 2 + S); chk(1'b1, "R2 held after manual release");
    at(m1 + G + 3 + S); chk(1'b0, "R2 release after manual reset");
  endtask

  initial begin
    int rel;
    t_power_on();
    t_float();
    t_timeout(rel);
    t_kick_toggle(rel);
    t_kick_pulse(rel);
    t_uv(rel);
    t_mr();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule